// File: doc/BRIEF.md
# Timer Channel Output Pin Controller

This block turns timer events into the level of one output pin. The events are single-cycle strobes. A mode bit picks one of two behaviours. In toggle mode, each toggle strobe inverts an internal level register. In combination mode, separate set and reset strobes force the level. A polarity bit decides which pin level counts as active, and a reset strobe wins when it coincides with a set strobe. Counters and event generation sit outside the block.

A small write-only register interface holds the mode, the polarity and an output enable. It also lets software write the level register directly. While the output is disabled, the pin is held at 0 and software can prepare the default level that appears once enable goes to 1. A timer event and a software level write in the same cycle resolve in favour of the event. The level register changes at most once per clock, so the pin never glitches.

Top module: `tout_pin_ctrl`

## Requirements
- R1: While `rst_n` is 0 at a rising clock edge, the level, mode, polarity and enable are cleared to 0, so the pin reads 0 after reset.
- R2: A write with `wr_en`=1 updates state at the next rising edge. Address 0 is the control word: bit 0 is the mode (0 = toggle, 1 = combination) and bit 1 is the polarity. Address 1 bit 0 is the output enable. Address 2 bit 0 is the level.
- R3: `pin_o` equals the level register while enable is 1 and is 0 while enable is 0. Disabling the output leaves the level register unchanged, and the stored level reappears when enable returns to 1.
- R4: In toggle mode, each cycle with `evt_toggle`=1 inverts the level. The strobes `evt_set` and `evt_reset` have no effect in this mode.
- R5: In toggle mode, the polarity bit has no effect on the level or on the pin.
- R6: In combination mode, `evt_set` drives the level to the active value (1 when polarity is 0, 0 when polarity is 1). `evt_reset` drives it to the opposite value. `evt_toggle` has no effect in this mode.
- R7: In combination mode, when `evt_set` and `evt_reset` are both 1 in one cycle, the reset result is taken.
- R8: Writing the polarity or the mode does not change the present level. A new polarity first acts at the next set or reset event.
- R9: A level write in a cycle with no effective event stores the written bit. While the output is disabled, this sets the default level that the pin shows once enabled.
- R10: When an effective timer event and a level write occur in the same cycle, the event result is stored and the written bit is discarded.
- R11: Writes to address 3 change neither the level, the mode, the polarity nor the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_toggle | input | 1 | Toggle strobe, used in toggle mode |
| evt_set | input | 1 | Set strobe, used in combination mode |
| evt_reset | input | 1 | Reset strobe, used in combination mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (2) | Register write address |
| wr_data | input | DATA_W (8) | Register write data |
| pin_o | output | 1 | Timer output pin level |

## Verification
The bench builds the block with its default parameters: a 2-bit address, an 8-bit data word and the control, enable and level registers at addresses 0, 1 and 2. Because the address is 2 bits wide, address 3 is free. This makes the writes to an unused address for R11 reachable. The 8-bit data word lets a write carry stray upper bits, which must be ignored. The polarity and mode fields sit in the low bits, so every combination of mode and polarity can be reached with a single write. This covers reset priority and deferred polarity under both active levels.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    typedef enum logic {
        MODE_TOGGLE = 1'b0,
        MODE_COMBO  = 1'b1
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  pol;
        logic  en;
    } cfg_t;

    typedef struct packed {
        logic lvl;
    } lvl_state_t;

    localparam int CTRL_MODE_BIT = 0;
    localparam int CTRL_POL_BIT  = 1;
    localparam int EN_BIT        = 0;
    localparam int LVL_BIT       = 0;

endpackage

// File: rtl/tpc_regs.sv
module tpc_regs
    import tpc_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int DATA_W   = 8,
    parameter int ADR_CTRL = 0,
    parameter int ADR_EN   = 1,
    parameter int ADR_LVL  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg_o,
    output logic              lvl_wr_o,
    output logic              lvl_val_o
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ADR_EN);
    localparam logic [ADDR_W-1:0] A_LVL  = ADDR_W'(ADR_LVL);

    cfg_t cfg_d, cfg_q;
    logic unused_data;

    assign unused_data = ^wr_data;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && (wr_addr == A_CTRL)) begin
            cfg_d.mode = mode_e'(wr_data[CTRL_MODE_BIT]);
            cfg_d.pol  = wr_data[CTRL_POL_BIT];
        end
        if (wr_en && (wr_addr == A_EN)) begin
            cfg_d.en = wr_data[EN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{mode: MODE_TOGGLE, pol: 1'b0, en: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o     = cfg_q;
    assign lvl_wr_o  = wr_en && (wr_addr == A_LVL);
    assign lvl_val_o = wr_data[LVL_BIT];

endmodule

// File: rtl/tpc_level.sv
module tpc_level
    import tpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cfg_t cfg,
    input  logic evt_toggle,
    input  logic evt_set,
    input  logic evt_reset,
    input  logic lvl_wr,
    input  logic lvl_val,
    output logic lvl_o
);

    lvl_state_t st_d, st_q;
    logic       hit;
    logic       evt_lvl;

    always_comb begin
        hit     = 1'b0;
        evt_lvl = st_q.lvl;
        if (cfg.mode == MODE_TOGGLE) begin
            if (evt_toggle) begin
                hit     = 1'b1;
                evt_lvl = ~st_q.lvl;
            end
        end else begin
            // reset outranks set
            if (evt_reset) begin
                hit     = 1'b1;
                evt_lvl = cfg.pol;
            end else if (evt_set) begin
                hit     = 1'b1;
                evt_lvl = ~cfg.pol;
            end
        end

        st_d = st_q;
        if (hit) begin
            st_d.lvl = evt_lvl;
        end else if (lvl_wr) begin
            st_d.lvl = lvl_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{lvl: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.lvl;

endmodule

// File: rtl/tout_pin_ctrl.sv
module tout_pin_ctrl
    import tpc_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int DATA_W   = 8,
    parameter int ADR_CTRL = 0,
    parameter int ADR_EN   = 1,
    parameter int ADR_LVL  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_toggle,
    input  logic              evt_set,
    input  logic              evt_reset,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pin_o
);

    cfg_t cfg;
    logic lvl_wr;
    logic lvl_val;
    logic lvl;

    tpc_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .ADR_CTRL(ADR_CTRL),
        .ADR_EN  (ADR_EN),
        .ADR_LVL (ADR_LVL)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cfg_o    (cfg),
        .lvl_wr_o (lvl_wr),
        .lvl_val_o(lvl_val)
    );

    tpc_level u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .evt_toggle(evt_toggle),
        .evt_set   (evt_set),
        .evt_reset (evt_reset),
        .lvl_wr    (lvl_wr),
        .lvl_val   (lvl_val),
        .lvl_o     (lvl)
    );

    // pin gated by enable; level register untouched by the gate
    assign pin_o = cfg.en ? lvl : 1'b0;

endmodule

// File: rtl/tpc_chk.sv
module tpc_chk
    import tpc_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int DATA_W   = 8,
    parameter int ADR_EN   = 1,
    parameter int ADR_LVL  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_toggle,
    input logic              evt_set,
    input logic              evt_reset,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              pin_o,
    input cfg_t              cfg,
    input logic              lvl
);

    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(ADR_EN);
    localparam logic [ADDR_W-1:0] A_LVL = ADDR_W'(ADR_LVL);

    logic any_evt;
    logic lvl_write;
    assign any_evt   = (cfg.mode == MODE_TOGGLE) ? evt_toggle : (evt_set | evt_reset);
    assign lvl_write = wr_en && (wr_addr == A_LVL);

    // R1: first cycle out of reset sees everything cleared
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!lvl && !pin_o && !cfg.en && !cfg.pol && cfg.mode == MODE_TOGGLE));

    // R3: clearing enable forces the pin low next cycle
    a_r3_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_EN && !wr_data[EN_BIT]) |=> !pin_o);

    // R4: toggle strobe in toggle mode inverts the level
    a_r4_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == MODE_TOGGLE && evt_toggle) |=> (lvl != $past(lvl)));

    // R6: lone set in combination mode gives the active level
    a_r6_set_active: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == MODE_COMBO && evt_set && !evt_reset) |=> (lvl == !$past(cfg.pol)));

    // R7: coincident set and reset give the reset result
    a_r7_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == MODE_COMBO && evt_set && evt_reset) |=> (lvl == $past(cfg.pol)));

    // R8: without an effective event or level write, the level holds
    a_r8_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_evt && !lvl_write) |=> $stable(lvl));

endmodule

bind tout_pin_ctrl tpc_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ADR_EN (ADR_EN),
    .ADR_LVL(ADR_LVL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_toggle(evt_toggle),
    .evt_set   (evt_set),
    .evt_reset (evt_reset),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pin_o     (pin_o),
    .cfg       (cfg),
    .lvl       (lvl)
);

// File: tb/tout_pin_ctrl_tb.sv
module tout_pin_ctrl_tb;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              evt_toggle = 1'b0;
    logic              evt_set = 1'b0;
    logic              evt_reset = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              pin_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // behavioural model state
    bit m_mode, m_pol, m_en, m_lvl;

    always #(CLK_P/2) clk = ~clk;

    tout_pin_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_toggle(evt_toggle),
        .evt_set   (evt_set),
        .evt_reset (evt_reset),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pin_o     (pin_o)
    );

    task automatic check(string tag, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pin actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic step(string tag, bit tg, bit st, bit rs, bit we, int addr, int data, int exp);
        bit hit;
        bit nl;
        evt_toggle = tg; evt_set = st; evt_reset = rs;
        wr_en = we; wr_addr = ADDR_W'(addr); wr_data = DATA_W'(data);
        @(posedge clk);
        hit = 1'b0;
        nl  = m_lvl;
        if (m_mode == 1'b0) begin
            if (tg) begin hit = 1'b1; nl = !m_lvl; end
        end else if (rs) begin
            hit = 1'b1; nl = m_pol;
        end else if (st) begin
            hit = 1'b1; nl = !m_pol;
        end
        if (hit) m_lvl = nl;
        else if (we && addr == 2) m_lvl = data[0];
        if (we && addr == 0) begin m_mode = data[0]; m_pol = data[1]; end
        if (we && addr == 1) m_en = data[0];
        @(negedge clk);
        evt_toggle = 1'b0; evt_set = 1'b0; evt_reset = 1'b0; wr_en = 1'b0;
        check({tag, " model"}, pin_o, m_en & m_lvl);
        if (exp >= 0) check({tag, " literal"}, pin_o, exp[0]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        m_mode = 0; m_pol = 0; m_en = 0; m_lvl = 0;
        @(negedge clk);
        check("R1 pin in reset", pin_o, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: enable only, level must be cleared
        step("R1 level cleared", 0,0,0, 1, 1, 1, 0);
        // R3/R9: default level while disabled
        step("R2 disable",        0,0,0, 1, 1, 0, 0);
        step("R9 default lvl=1",  0,0,0, 1, 2, 1, 0);
        step("R3 disabled holds", 0,0,0, 0, 0, 0, 0);
        step("R9 enable shows default", 0,0,0, 1, 1, 1, 1);
        // R4 toggle mode
        step("R4 toggle 1->0", 1,0,0, 0, 0, 0, 0);
        step("R4 toggle 0->1", 1,0,0, 0, 0, 0, 1);
        step("R4 set ignored", 0,1,0, 0, 0, 0, 1);
        step("R4 reset ignored", 0,0,1, 0, 0, 0, 1);
        step("R4 both ignored", 0,1,1, 0, 0, 0, 1);
        // R5 polarity in toggle mode
        step("R5 pol write no effect", 0,0,0, 1, 0, 2, 1);
        step("R5 toggle with pol=1", 1,0,0, 0, 0, 0, 0);
        step("R5 toggle with pol=1 again", 1,0,0, 0, 0, 0, 1);
        // R8 mode change keeps level; R6 combination, pol=0
        step("R8 mode->combo keeps lvl", 0,0,0, 1, 0, 1, 1);
        step("R6 reset pol0", 0,0,1, 0, 0, 0, 0);
        step("R6 set pol0", 0,1,0, 0, 0, 0, 1);
        step("R6 toggle ignored", 1,0,0, 0, 0, 0, 1);
        step("R7 both pol0", 0,1,1, 0, 0, 0, 0);
        // R8 polarity change keeps level, applies at next event
        step("R8 pol->1 keeps lvl", 0,0,0, 1, 0, 3, 0);
        step("R8 idle after pol", 0,0,0, 0, 0, 0, 0);
        step("R6 reset pol1", 0,0,1, 0, 0, 0, 1);
        step("R6 set pol1", 0,1,0, 0, 0, 0, 0);
        step("R7 both pol1", 0,1,1, 0, 0, 0, 1);
        step("R8 pol->0 keeps lvl", 0,0,0, 1, 0, 1, 1);
        step("R8 set after pol0", 0,1,0, 0, 0, 0, 1);
        step("R8 reset after pol0", 0,0,1, 0, 0, 0, 0);
        // R10 event vs level write, combination mode
        step("R10 set beats write 0", 0,1,0, 1, 2, 0, 1);
        step("R10 reset beats write 1", 0,0,1, 1, 2, 1, 0);
        step("R10 ignored toggle lets write", 1,0,0, 1, 2, 1, 1);
        // R10 in toggle mode
        step("R2 mode->toggle", 0,0,0, 1, 0, 0, 1);
        step("R10 toggle beats write 1", 1,0,0, 1, 2, 1, 0);
        step("R10 set ignored lets write", 0,1,0, 1, 2, 1, 1);
        // R9 write while enabled, no event
        step("R9 write 0 enabled", 0,0,0, 1, 2, 0, 0);
        step("R9 write upper bits ignored", 0,0,0, 1, 2, 8'hFF, 1);
        // R11 unused address
        step("R11 addr3 write", 0,0,0, 1, 3, 8'hFF, 1);
        step("R11 still toggle mode", 1,0,0, 0, 0, 0, 0);
        step("R11 addr3 write zero", 0,0,0, 1, 3, 0, 0);
        step("R11 enable kept", 1,0,0, 0, 0, 0, 1);
        // R3 gate keeps level
        step("R3 disable", 0,0,0, 1, 1, 0, 0);
        step("R3 toggle while disabled", 1,0,0, 0, 0, 0, 0);
        step("R3 re-enable shows lvl", 0,0,0, 1, 1, 1, 0);
        step("R3 toggle enabled", 1,0,0, 0, 0, 0, 1);
        // R1 mid-run reset
        step("R2 combo pol1", 0,0,0, 1, 0, 3, 1);
        do_reset();
        step("R1 enable after reset", 0,0,0, 1, 1, 1, 0);
        step("R1 mode cleared", 1,0,0, 0, 0, 0, 1);
        step("R1 pol cleared", 1,0,0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule